// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits behind a 10-bit analog-to-digital converter and takes each finished result when a one-cycle done strobe arrives. It registers the result as a pair of output bytes, packed toward the top or toward the bottom as a control bit selects. In the same cycle it tests the upper eight bits of the result against two 8-bit bounds that software writes.

The test gives a single match flag. One control bit decides whether the flag means "inside the window" or "outside the window". The flag comes from an exclusive-OR rule, so it stays well defined even when the low bound is above the high bound. A conversion interrupt goes pending either on every conversion or only on matching ones. It stays pending until software writes a one to clear it.

All settings live in a small register file with a write port and a read port. Registers: 0 control, 1 high bound, 2 low bound, 3 status, 4 result high byte, 5 result low byte. Control bits: bit 0 format (0 = packed high, 1 = packed low), bit 1 window mode (0 = inside, 1 = outside), bit 2 qualify, bit 3 interrupt enable. Status bits: bit 0 match, bit 1 interrupt pending.

Top module: `adcw_top`

## Requirements
- R1: After reset, every register reads 0, and `res_hi_o`, `res_lo_o`, `match_o` and `irq_o` are 0.
- R2: With format bit 0, one cycle after a done strobe `res_hi_o` equals result bits 9..2, and `res_lo_o` holds result bits 1..0 in its bits 7..6 with zeros below them.
- R3: With format bit 1, one cycle after a done strobe `res_hi_o` holds result bits 9..8 in its bits 1..0 with zeros in bits 7..2, and `res_lo_o` equals result bits 7..0.
- R4: On every done strobe, `match_o` is updated one cycle later to mode XOR (high bound <= M) XOR (low bound <= M), where M is result bits 9..2.
- R5: In inside mode (mode 0) with the high bound above the low bound, the flag is 1 exactly when low bound <= M < high bound.
- R6: In outside mode (mode 1) with the high bound above the low bound, the flag is 1 exactly when M >= high bound or M < low bound.
- R7: When the low bound is greater than the high bound, the flag still follows the R4 rule exactly.
- R8: With qualify 0 and interrupt enable 1, every done strobe sets the pending bit, so `irq_o` is 1 one cycle later. With interrupt enable 0, a done strobe never sets it.
- R9: With qualify 1, a done strobe sets the pending bit only when the new match flag is 1.
- R10: Writing status with bit 1 = 1 clears the pending bit. Writing status with bit 1 = 0 has no effect on it. If a set and a clear occur in the same cycle, the set wins.
- R11: A register write in the same cycle as a done strobe does not affect that conversion; the new value applies from the next conversion onward.
- R12: Between done strobes, the result bytes and `match_o` hold their values.
- R13: An all-ones result and an all-zeros result are compared correctly against bounds of 0xFF and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: result is valid |
| conv_res_i | input | 10 | Conversion result |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |
| match_o | output | 1 | Window match flag |
| irq_o | output | 1 | Conversion interrupt pending |

## Verification
The hardest cases to reach from the ports are collisions inside a single clock edge. In one, a control or bound write lands in the same cycle as a done strobe. In the other, a pending-clear write lands in the same cycle as a qualifying conversion. The bench produces both by driving the strobe and the write together on one falling edge. It then reads the outputs one cycle later, to check that the old settings were used and that the set took priority over the clear. A follow-up conversion confirms that the written value then takes effect. Bounds are placed so that the result bits sit exactly on each bound, one below it, and at the extremes 0x00 and 0xFF. This exercises the inclusive and exclusive edges of the window, including with the bounds in inverted order.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL  = 3'd0,
      RA_BHI   = 3'd1,
      RA_BLO   = 3'd2,
      RA_STAT  = 3'd3,
      RA_RESHI = 3'd4,
      RA_RESLO = 3'd5
   } reg_addr_e;

   // control register bit positions
   localparam int CB_FMT  = 0;
   localparam int CB_MODE = 1;
   localparam int CB_QUAL = 2;
   localparam int CB_IEN  = 3;
   // status register bit positions
   localparam int SB_MATCH = 0;
   localparam int SB_PEND  = 1;

   typedef struct packed {
      logic ien;
      logic qual;
      logic mode;
      logic fmt;
   } ctrl_t;
endpackage

// File: rtl/adcw_format.sv
module adcw_format #(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8
) (
   input  logic [RES_W-1:0]  res_i,
   input  logic              right_i,
   output logic [BYTE_W-1:0] hi_o,
   output logic [BYTE_W-1:0] lo_o
);
   localparam int SPILL  = RES_W - BYTE_W;
   localparam int HI_PAD = BYTE_W - SPILL;

   logic [BYTE_W-1:0] hi_left, lo_left, hi_right, lo_right;

   generate
      if (RES_W <= BYTE_W || RES_W > 2*BYTE_W) begin : g_bad
         $error("adcw_format: RES_W must lie in (BYTE_W, 2*BYTE_W]");
      end
      if (HI_PAD == 0) begin : g_nopad
         assign lo_left  = res_i[SPILL-1:0];
         assign hi_right = res_i[RES_W-1:BYTE_W];
      end else begin : g_pad
         assign lo_left  = {res_i[SPILL-1:0], {HI_PAD{1'b0}}};
         assign hi_right = {{HI_PAD{1'b0}}, res_i[RES_W-1:BYTE_W]};
      end
   endgenerate

   assign hi_left  = res_i[RES_W-1 -: BYTE_W];
   assign lo_right = res_i[BYTE_W-1:0];

   always_comb begin
      if (right_i) begin
         hi_o = hi_right;
         lo_o = lo_right;
      end else begin
         hi_o = hi_left;
         lo_o = lo_left;
      end
   end
endmodule

// File: rtl/adcw_window.sv
module adcw_window #(
   parameter int CMP_W = 8
) (
   input  logic [CMP_W-1:0] msb_i,
   input  logic [CMP_W-1:0] bound_hi_i,
   input  logic [CMP_W-1:0] bound_lo_i,
   input  logic             outside_i,
   output logic             hit_o
);
   logic ge_hi, ge_lo;

   generate
      if (CMP_W < 1) begin : g_bad
         $error("adcw_window: CMP_W must be positive");
      end
   endgenerate

   assign ge_hi = (bound_hi_i <= msb_i);
   assign ge_lo = (bound_lo_i <= msb_i);
   assign hit_o = outside_i ^ ge_hi ^ ge_lo;
endmodule

// File: rtl/adcw_regs.sv
module adcw_regs
   import adcw_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              pend_set_i,
   output ctrl_t             ctrl_o,
   output logic [BYTE_W-1:0] bound_hi_o,
   output logic [BYTE_W-1:0] bound_lo_o,
   output logic              pend_o
);
   logic pend_clr;

   generate
      if (BYTE_W < 4) begin : g_bad
         $error("adcw_regs: BYTE_W must hold the control bits");
      end
   endgenerate

   assign pend_clr = wr_en_i && (wr_addr_i == RA_STAT) && wr_data_i[SB_PEND];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o     <= '0;
         bound_hi_o <= '0;
         bound_lo_o <= '0;
      end else if (wr_en_i) begin
         case (wr_addr_i)
            RA_CTRL: ctrl_o <= ctrl_t'({wr_data_i[CB_IEN], wr_data_i[CB_QUAL],
                                        wr_data_i[CB_MODE], wr_data_i[CB_FMT]});
            RA_BHI:  bound_hi_o <= wr_data_i;
            RA_BLO:  bound_lo_o <= wr_data_i;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_o <= 1'b0;
      else if (pend_set_i) pend_o <= 1'b1;
      else if (pend_clr)   pend_o <= 1'b0;
   end

   // R10: a clear with no set in the same cycle drops the pending bit
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr && !pend_set_i) |=> !pend_o);
   // R10: set takes priority over clear
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set_i |=> pend_o);
endmodule

// File: rtl/adcw_top.sv
module adcw_top
   import adcw_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done_i,
   input  logic [RES_W-1:0]  conv_res_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [BYTE_W-1:0] res_hi_o,
   output logic [BYTE_W-1:0] res_lo_o,
   output logic              match_o,
   output logic              irq_o
);
   localparam int CMP_W = BYTE_W;

   ctrl_t             ctrl;
   logic [BYTE_W-1:0] bound_hi, bound_lo;
   logic [BYTE_W-1:0] fmt_hi, fmt_lo;
   logic [CMP_W-1:0]  msb;
   logic              hit, pend_set, pend;

   assign msb = conv_res_i[RES_W-1 -: CMP_W];

   adcw_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .pend_set_i (pend_set),
      .ctrl_o     (ctrl),
      .bound_hi_o (bound_hi),
      .bound_lo_o (bound_lo),
      .pend_o     (pend)
   );

   adcw_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
      .res_i   (conv_res_i),
      .right_i (ctrl.fmt),
      .hi_o    (fmt_hi),
      .lo_o    (fmt_lo)
   );

   adcw_window #(.CMP_W(CMP_W)) u_win (
      .msb_i      (msb),
      .bound_hi_i (bound_hi),
      .bound_lo_i (bound_lo),
      .outside_i  (ctrl.mode),
      .hit_o      (hit)
   );

   assign pend_set = conv_done_i && ctrl.ien && (!ctrl.qual || hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hi_o <= '0;
         res_lo_o <= '0;
         match_o  <= 1'b0;
      end else if (conv_done_i) begin
         res_hi_o <= fmt_hi;
         res_lo_o <= fmt_lo;
         match_o  <= hit;
      end
   end

   assign irq_o = pend;

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         RA_CTRL: begin
            rd_data_o[CB_FMT]  = ctrl.fmt;
            rd_data_o[CB_MODE] = ctrl.mode;
            rd_data_o[CB_QUAL] = ctrl.qual;
            rd_data_o[CB_IEN]  = ctrl.ien;
         end
         RA_BHI:   rd_data_o = bound_hi;
         RA_BLO:   rd_data_o = bound_lo;
         RA_STAT: begin
            rd_data_o[SB_MATCH] = match_o;
            rd_data_o[SB_PEND]  = pend;
         end
         RA_RESHI: rd_data_o = res_hi_o;
         RA_RESLO: rd_data_o = res_lo_o;
         default:  rd_data_o = '0;
      endcase
   end

   // R4: flag follows the XOR rule on the settings present at the strobe
   p_match_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done_i |=> match_o == ($past(ctrl.mode)
                                  ^ ($past(bound_hi) <= $past(msb))
                                  ^ ($past(bound_lo) <= $past(msb))));
   // R12: outputs hold between strobes
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done_i |=> ($stable(match_o) && $stable(res_hi_o) && $stable(res_lo_o)));
   // R8: unqualified enabled conversion always raises the interrupt
   p_unqual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && ctrl.ien && !ctrl.qual) |=> irq_o);
   // R9: a rising interrupt comes from an enabled strobe and, if qualified, a match
   p_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(conv_done_i) && $past(ctrl.ien)
                        && (!$past(ctrl.qual) || match_o)));
endmodule

// File: tb/tb_adcw_top.sv
module tb_adcw_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_done_i = 1'b0;
   logic [9:0] conv_res_i = '0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [2:0] rd_addr_i = '0;
   logic [7:0] rd_data_o, res_hi_o, res_lo_o;
   logic       match_o, irq_o;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   adcw_top dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk); wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); rd_addr_i = a; #1 d = rd_data_o;
   endtask

   task automatic conv(input logic [9:0] r);
      @(negedge clk); conv_done_i = 1'b1; conv_res_i = r;
      @(negedge clk); conv_done_i = 1'b0;
   endtask

   function automatic logic ref_match(input logic mode, input logic [7:0] hi,
                                      input logic [7:0] lo, input logic [7:0] m);
      if (hi > lo) return mode ? (m >= hi || m < lo) : (m >= lo && m < hi);
      return mode ^ (hi <= m) ^ (lo <= m);
   endfunction

   task automatic t_reset;
      logic [7:0] d;
      for (int a = 0; a < 6; a++) begin
         rd(a[2:0], d);
         check("R1 reg", d, 0);
      end
      check("R1 outputs", {res_hi_o, res_lo_o, match_o, irq_o}, 0);
   endtask

   task automatic t_format;
      logic [7:0] d;
      wr(3'd0, 8'h00);
      conv(10'h2D7);
      check("R2 hi", res_hi_o, 8'hB5);
      check("R2 lo", res_lo_o, 8'hC0);
      rd(3'd4, d); check("R2 read hi", d, 8'hB5);
      repeat (3) @(negedge clk);
      check("R12 hold", {res_hi_o, res_lo_o}, 16'hB5C0);
      wr(3'd0, 8'h01);
      conv(10'h2D7);
      check("R3 hi", res_hi_o, 8'h02);
      check("R3 lo", res_lo_o, 8'hD7);
   endtask

   task automatic sweep(input string req, input logic mode, input logic [7:0] hi,
                        input logic [7:0] lo);
      logic [7:0] ms [6];
      ms = '{lo - 8'd1, lo, lo + 8'd1, hi - 8'd1, hi, hi + 8'd1};
      wr(3'd0, {6'd0, mode, 1'b0});
      wr(3'd1, hi); wr(3'd2, lo);
      foreach (ms[i]) begin
         conv({ms[i], 2'b10});
         check(req, match_o, ref_match(mode, hi, lo, ms[i]));
      end
   endtask

   task automatic t_window;
      sweep("R5 inside", 1'b0, 8'h80, 8'h40);
      sweep("R4 inside", 1'b0, 8'h21, 8'h20);
      sweep("R6 outside", 1'b1, 8'h80, 8'h40);
      sweep("R7 inverted", 1'b0, 8'h30, 8'h90);
      sweep("R7 inverted out", 1'b1, 8'h30, 8'h90);
      sweep("R7 equal", 1'b0, 8'h55, 8'h55);
   endtask

   task automatic t_edges;
      wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
      conv(10'h3FF); check("R13 full inside", match_o, 1'b0);
      conv(10'h000); check("R13 zero inside", match_o, 1'b1);
      wr(3'd0, 8'h02);
      conv(10'h3FF); check("R13 full outside", match_o, 1'b1);
      conv(10'h000); check("R13 zero outside", match_o, 1'b0);
   endtask

   task automatic t_irq;
      wr(3'd1, 8'h80); wr(3'd2, 8'h40);
      wr(3'd0, 8'h00);
      conv(10'h000); check("R8 disabled", irq_o, 1'b0);
      wr(3'd0, 8'h08);
      conv(10'h000); check("R8 unqualified", irq_o, 1'b1);
      wr(3'd3, 8'h01); check("R10 write zero keeps", irq_o, 1'b1);
      wr(3'd3, 8'h02); check("R10 clear", irq_o, 1'b0);
      wr(3'd0, 8'h0C);
      conv(10'h000); check("R9 no match", irq_o, 1'b0);
      conv({8'h50, 2'b00}); check("R9 match", irq_o, 1'b1);
      // set and clear collide
      @(negedge clk); conv_done_i = 1'b1; conv_res_i = {8'h50, 2'b00};
      wr_en_i = 1'b1; wr_addr_i = 3'd3; wr_data_i = 8'h02;
      @(negedge clk); conv_done_i = 1'b0; wr_en_i = 1'b0;
      check("R10 set wins", irq_o, 1'b1);
      wr(3'd3, 8'h02); check("R10 clear after", irq_o, 1'b0);
   endtask

   task automatic t_collide;
      wr(3'd0, 8'h00); wr(3'd1, 8'h80); wr(3'd2, 8'h40);
      @(negedge clk); conv_done_i = 1'b1; conv_res_i = {8'h50, 2'b00};
      wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'h02;
      @(negedge clk); conv_done_i = 1'b0; wr_en_i = 1'b0;
      check("R11 old mode used", match_o, 1'b1);
      conv({8'h50, 2'b00});
      check("R11 new mode next", match_o, 1'b0);
      @(negedge clk); conv_done_i = 1'b1; conv_res_i = {8'h50, 2'b00};
      wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 8'h20;
      @(negedge clk); conv_done_i = 1'b0; wr_en_i = 1'b0;
      check("R11 old bound used", match_o, 1'b0);
      conv({8'h50, 2'b00});
      check("R11 new bound next", match_o, ref_match(1'b1, 8'h20, 8'h40, 8'h50));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_format();
      t_window();
      t_edges();
      t_irq();
      t_collide();
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule